// File: doc/BRIEF.md
# Dual-Base Logarithmic Multiply/Divide Normalizer

This block multiplies or divides two values held in a dual-base logarithmic form. A non-zero value is a sign together with a power of two and a power of e: magnitude = 2^E * e^F. E is a signed integer. F is an unsigned fixed-point fraction with `FRAC_W` fractional bits, kept in the range [0, ln 2) so that e^F acts as a significand in [1, 2). A separate flag marks the value zero. Multiplication adds both exponent pairs. Division subtracts them.

The combined fraction can leave its range. A multiply can push it to ln 2 or above, and a divide can make it negative. The block then moves one rounded ln 2 between the fraction and the base-2 exponent, and the base-2 exponent moves by one step to balance it. Results that need no such move are exact. Results that do need it carry the small error of the rounded constant.

A result is registered one cycle after it is presented. It is used as the multiply/divide stage of a log-domain arithmetic pipeline. Flags report a zero result, a division by zero, and a base-2 exponent outside its signed range.

Top module: `dbl_mul_norm`

## Requirements
- R1: With `op`=0 (multiply) and non-zero operands, when x_frac+y_frac is below LN2_Q = round(ln2 * 2^FRAC_W), the result is out_exp = x_exp+y_exp and out_frac = x_frac+y_frac.
- R2: With `op`=0, when x_frac+y_frac is at least LN2_Q, the result is out_frac = x_frac+y_frac-LN2_Q and out_exp = x_exp+y_exp+1.
- R3: With `op`=1 (divide) and non-zero operands, when x_frac >= y_frac, the result is out_exp = x_exp-y_exp and out_frac = x_frac-y_frac.
- R4: With `op`=1, when x_frac < y_frac, the result is out_frac = x_frac-y_frac+LN2_Q and out_exp = x_exp-y_exp-1.
- R5: For non-zero operands, out_sign is the XOR of x_sign and y_sign.
- R6: When either operand has its zero flag set, out_zero is 1 and out_sign, out_exp, out_frac, out_ovf and out_unf are all 0.
- R7: A divide with y_zero=1 sets out_div_err=1 together with out_zero=1. In every other case out_div_err is 0.
- R8: If the true result exponent exceeds 2^(EXP_W-1)-1, out_ovf is 1. If it is below -2^(EXP_W-1), out_unf is 1. In both cases out_exp holds the low EXP_W bits of the true exponent.
- R9: Results appear on the clock edge after the one that samples in_vld=1, and out_vld is then 1. A cycle with in_vld=0 gives out_vld=0 and leaves the result fields unchanged.
- R10: Synchronous active-high reset sets out_vld, out_sign, out_zero, out_exp, out_frac and all flags to 0.
- R11: For normalized inputs, every valid non-zero result has out_frac < LN2_Q. Its decoded value matches the real product or quotient within a relative error of 1e-3 when FRAC_W=10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and op are valid this cycle |
| op | input | 1 | 0 = multiply, 1 = divide (x / y) |
| x_sign | input | 1 | Sign of x, 1 = negative |
| x_zero | input | 1 | x is zero |
| x_exp | input | EXP_W | Signed base-2 exponent of x |
| x_frac | input | FRAC_W | Base-e fraction of x, below LN2_Q |
| y_sign | input | 1 | Sign of y |
| y_zero | input | 1 | y is zero |
| y_exp | input | EXP_W | Signed base-2 exponent of y |
| y_frac | input | FRAC_W | Base-e fraction of y, below LN2_Q |
| out_vld | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_zero | output | 1 | Result is zero |
| out_exp | output | EXP_W | Result base-2 exponent (low bits when out of range) |
| out_frac | output | FRAC_W | Normalized result base-e fraction |
| out_ovf | output | 1 | Result exponent above range |
| out_unf | output | 1 | Result exponent below range |
| out_div_err | output | 1 | Divide by zero |

## Verification
The bench builds the block with EXP_W=6 and FRAC_W=10, which makes LN2_Q equal to 710 and the exponent range -32 to 31. With these small widths, hand-computed vectors can reach every important point. These include a fraction sum of exactly 710 and of 709, the largest pair 709+709, a divide whose difference is exactly zero, and a divide whose difference is one below zero. They also include exponents of exactly 31 and -32, and the step just past each bound, where one renormalization carry alone causes the overflow or underflow. Each ordinary result is also decoded to a real number and compared with a real-valued product or quotient.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } dbl_op_e;

  // ln 2 scaled by 2^fw, rounded to nearest
  function automatic int unsigned ln2_fixed(input int fw);
    real scaled;
    scaled = 0.6931471805599453 * (2.0 ** fw);
    return int'($rtoi(scaled + 0.5));
  endfunction

endpackage

// File: rtl/dbl_frac_norm.sv
module dbl_frac_norm #(
  parameter int          FRAC_W = 23,
  parameter int unsigned LN2_Q  = 5814540
) (
  input  logic                op_div,
  input  logic [FRAC_W-1:0]   x_frac,
  input  logic [FRAC_W-1:0]   y_frac,
  output logic [FRAC_W-1:0]   frac_o,
  output logic signed [1:0]   adj_o
);
  localparam int SW = FRAC_W + 2;
  localparam logic signed [SW-1:0] L_S = SW'(LN2_Q);

  logic signed [SW-1:0] xs, ys, raw, fixed;

  always_comb begin
    xs = $signed({2'b00, x_frac});
    ys = $signed({2'b00, y_frac});
    raw = op_div ? (xs - ys) : (xs + ys);
    fixed = raw;
    adj_o = 2'sd0;
    if (!op_div && (raw >= L_S)) begin
      fixed = raw - L_S;
      adj_o = 2'sd1;
    end else if (op_div && (raw < 0)) begin
      fixed = raw + L_S;
      adj_o = -2'sd1;
    end
    frac_o = fixed[FRAC_W-1:0];
  end

endmodule

// File: rtl/dbl_exp_comb.sv
module dbl_exp_comb #(
  parameter int EXP_W = 8
) (
  input  logic                  op_div,
  input  logic [EXP_W-1:0]      x_exp,
  input  logic [EXP_W-1:0]      y_exp,
  input  logic signed [1:0]     adj,
  output logic [EXP_W-1:0]      exp_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  localparam int SW = EXP_W + 2;
  localparam logic signed [SW-1:0] E_MAX = SW'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [SW-1:0] E_MIN = -SW'(2 ** (EXP_W - 1));

  logic signed [SW-1:0] xe, ye, ae, sum;

  always_comb begin
    xe = $signed({{2{x_exp[EXP_W-1]}}, x_exp});
    ye = $signed({{2{y_exp[EXP_W-1]}}, y_exp});
    ae = $signed({{EXP_W{adj[1]}}, adj});
    sum = (op_div ? (xe - ye) : (xe + ye)) + ae;
    ovf_o = sum > E_MAX;
    unf_o = sum < E_MIN;
    exp_o = sum[EXP_W-1:0];
  end

endmodule

// File: rtl/dbl_mul_norm.sv
module dbl_mul_norm
  import dbl_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              op,
  input  logic              x_sign,
  input  logic              x_zero,
  input  logic [EXP_W-1:0]  x_exp,
  input  logic [FRAC_W-1:0] x_frac,
  input  logic              y_sign,
  input  logic              y_zero,
  input  logic [EXP_W-1:0]  y_exp,
  input  logic [FRAC_W-1:0] y_frac,
  output logic              out_vld,
  output logic              out_sign,
  output logic              out_zero,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_div_err
);
  localparam int unsigned LN2_Q = ln2_fixed(FRAC_W);

  dbl_op_e          op_e;
  logic             is_div;
  logic [FRAC_W-1:0] n_frac;
  logic signed [1:0] n_adj;
  logic [EXP_W-1:0] n_exp;
  logic             n_ovf, n_unf;
  logic             res_zero, res_div_err;

  assign op_e        = dbl_op_e'(op);
  assign is_div      = (op_e == OP_DIV);
  assign res_zero    = x_zero | y_zero;
  assign res_div_err = is_div & y_zero;

  dbl_frac_norm #(.FRAC_W(FRAC_W), .LN2_Q(LN2_Q)) u_frac (
    .op_div (is_div),
    .x_frac (x_frac),
    .y_frac (y_frac),
    .frac_o (n_frac),
    .adj_o  (n_adj)
  );

  dbl_exp_comb #(.EXP_W(EXP_W)) u_exp (
    .op_div (is_div),
    .x_exp  (x_exp),
    .y_exp  (y_exp),
    .adj    (n_adj),
    .exp_o  (n_exp),
    .ovf_o  (n_ovf),
    .unf_o  (n_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_sign    <= 1'b0;
      out_zero    <= 1'b0;
      out_exp     <= '0;
      out_frac    <= '0;
      out_ovf     <= 1'b0;
      out_unf     <= 1'b0;
      out_div_err <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_div_err <= res_div_err;
        out_zero    <= res_zero;
        if (res_zero) begin
          out_sign <= 1'b0;
          out_exp  <= '0;
          out_frac <= '0;
          out_ovf  <= 1'b0;
          out_unf  <= 1'b0;
        end else begin
          out_sign <= x_sign ^ y_sign;
          out_exp  <= n_exp;
          out_frac <= n_frac;
          out_ovf  <= n_ovf;
          out_unf  <= n_unf;
        end
      end
    end
  end

  // R11: a valid non-zero result is normalized
  a_r11_frac_normalized: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_zero) |-> (out_frac < FRAC_W'(LN2_Q)));

  // R6: zero results are canonical
  a_r6_zero_canonical: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_zero) |-> (out_exp == '0 && out_frac == '0 && !out_sign && !out_ovf && !out_unf));

  // R7: a divide error always comes with a zero result
  a_r7_div_err_zero: assert property (@(posedge clk) disable iff (rst)
    out_div_err |-> out_zero);

  // R9: one-cycle latency
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R9: idle cycle holds the result
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(out_exp) && $stable(out_frac) && $stable(out_sign)));

  // R5: sign of a non-zero result
  a_r5_sign: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !x_zero && !y_zero) |=> (out_sign == $past(x_sign ^ y_sign)));

  // R8: range flags are exclusive
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_ovf && out_unf));

endmodule

// File: tb/tb_dbl_mul_norm.sv
module tb_dbl_mul_norm;
  localparam int EXP_W = 6;
  localparam int FRAC_W = 10;
  localparam int CLK_PERIOD = 10;
  localparam int LQ = $rtoi(0.6931471805599453 * 1024.0 + 0.5); // 710
  localparam int VW = 54;
  localparam int NV = 13;

  function automatic logic [VW-1:0] mk(input int op, input int xs, input int xe, input int xf,
                                       input int ys, input int ye, input int yf,
                                       input int es, input int ee, input int ef,
                                       input int ov, input int un);
    return {1'(op), 1'(xs), 6'(xe), 10'(xf), 1'(ys), 6'(ye), 10'(yf),
            1'(es), 6'(ee), 10'(ef), 1'(ov), 1'(un)};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0, 0,  3, 100, 0,  2, 200, 0,  5, 300, 0, 0),   // R1
    mk(0, 0,  1, 500, 1, -4, 400, 1, -2, 190, 0, 0),   // R2 R5
    mk(0, 1,  0, 709, 1,  0, 709, 0,  1, 708, 0, 0),   // R2 largest
    mk(0, 0,  0, 355, 0,  0, 355, 0,  1,   0, 0, 0),   // R2 exact boundary
    mk(0, 0,  0, 354, 0,  0, 355, 0,  0, 709, 0, 0),   // R1 boundary
    mk(1, 0,  7, 600, 0,  3, 100, 0,  4, 500, 0, 0),   // R3
    mk(1, 1,  2, 100, 0,  5, 300, 1, -4, 510, 0, 0),   // R4 R5
    mk(1, 0,  0,   0, 0,  0, 709, 0, -1,   1, 0, 0),   // R4 extreme
    mk(1, 0, -3, 250, 1, -3, 250, 1,  0,   0, 0, 0),   // R3 zero diff
    mk(0, 0, 20,   0, 0, 11,   0, 0, 31,   0, 0, 0),   // R8 top edge
    mk(0, 0, 20, 400, 0, 11, 400, 0, -32, 90, 1, 0),   // R8 overflow by carry
    mk(1, 0,-20,   0, 0, 12,   0, 0, -32,  0, 0, 0),   // R8 bottom edge
    mk(1, 0,-20,   0, 0, 12,   1, 0, 31, 709, 0, 1)    // R8 underflow by borrow
  };

  logic clk = 0, rst = 1, in_vld = 0, op = 0;
  logic x_sign = 0, x_zero = 0, y_sign = 0, y_zero = 0;
  logic [EXP_W-1:0] x_exp = '0, y_exp = '0;
  logic [FRAC_W-1:0] x_frac = '0, y_frac = '0;
  logic out_vld, out_sign, out_zero, out_ovf, out_unf, out_div_err;
  logic [EXP_W-1:0] out_exp;
  logic [FRAC_W-1:0] out_frac;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_mul_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op(op),
    .x_sign(x_sign), .x_zero(x_zero), .x_exp(x_exp), .x_frac(x_frac),
    .y_sign(y_sign), .y_zero(y_zero), .y_exp(y_exp), .y_frac(y_frac),
    .out_vld(out_vld), .out_sign(out_sign), .out_zero(out_zero),
    .out_exp(out_exp), .out_frac(out_frac), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_div_err(out_div_err)
  );

  task automatic chk(input string req, input string what, input int got, input int exp_v);
    n_chk++;
    if (got != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp_v);
    end
  endtask

  function automatic real decode(input logic s, input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
    real m;
    m = $pow(2.0, real'($signed(e))) * $exp(real'(f) / 1024.0);
    return s ? -m : m;
  endfunction

  // drive at negedge, result is registered at next posedge, sample at following negedge
  task automatic apply(input logic o, input logic xs, input logic xz, input logic [EXP_W-1:0] xe,
                       input logic [FRAC_W-1:0] xf, input logic ys, input logic yz,
                       input logic [EXP_W-1:0] ye, input logic [FRAC_W-1:0] yf);
    @(negedge clk);
    op = o; x_sign = xs; x_zero = xz; x_exp = xe; x_frac = xf;
    y_sign = ys; y_zero = yz; y_exp = ye; y_frac = yf; in_vld = 1;
    @(negedge clk);
    in_vld = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_vld", out_vld, 0);
    chk("R10", "out_zero", out_zero, 0);
    chk("R10", "out_exp", out_exp, 0);
    chk("R10", "out_frac", out_frac, 0);
    chk("R10", "flags", {out_ovf, out_unf, out_div_err}, 0);
    rst = 0;
    chk("R11", "ln2 constant", LQ, 710);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string rq;
      real ref_v, got_v, err;
      v = VEC[i];
      rq = v[53] ? ((v[45:36] < v[28:19]) ? "R4" : "R3")
                 : ((int'(v[45:36]) + int'(v[28:19]) >= LQ) ? "R2" : "R1");
      if (v[1] | v[0]) rq = "R8";
      apply(v[53], v[52], 1'b0, v[51:46], v[45:36], v[35], 1'b0, v[34:29], v[28:19]);
      chk("R9", "out_vld", out_vld, 1);
      chk("R5", "out_sign", out_sign, v[18]);
      chk(rq, "out_exp", $signed(out_exp), $signed(v[17:12]));
      chk(rq, "out_frac", out_frac, v[11:2]);
      chk("R8", "out_ovf", out_ovf, v[1]);
      chk("R8", "out_unf", out_unf, v[0]);
      chk("R6", "out_zero", out_zero, 0);
      if (!(v[1] | v[0])) begin
        chk("R11", "normalized", int'(out_frac < FRAC_W'(LQ)), 1);
        ref_v = v[53] ? decode(v[52], v[51:46], v[45:36]) / decode(v[35], v[34:29], v[28:19])
                      : decode(v[52], v[51:46], v[45:36]) * decode(v[35], v[34:29], v[28:19]);
        got_v = decode(out_sign, out_exp, out_frac);
        err = (got_v - ref_v) / ref_v;
        if (err < 0.0) err = -err;
        n_chk++;
        if (err > 1.0e-3) begin
          n_fail++;
          $display("FAIL R11 real value: got %f expected %f", got_v, ref_v);
        end
      end
    end

    // R9: idle cycle keeps the last result
    @(negedge clk);
    chk("R9", "idle out_vld", out_vld, 0);
    chk("R9", "idle out_frac held", out_frac, 709);
    chk("R9", "idle out_exp held", $signed(out_exp), 31);

    // R6: multiply by zero
    apply(1'b0, 1'b1, 1'b0, 6'd5, 10'd300, 1'b0, 1'b1, 6'd3, 10'd20);
    chk("R6", "mul zero out_zero", out_zero, 1);
    chk("R6", "mul zero fields", {out_sign, out_exp, out_frac, out_ovf, out_unf}, 0);
    chk("R7", "mul zero no div_err", out_div_err, 0);

    // R6: zero dividend
    apply(1'b1, 1'b1, 1'b1, 6'd4, 10'd10, 1'b0, 1'b0, 6'd2, 10'd30);
    chk("R6", "zero dividend out_zero", out_zero, 1);
    chk("R6", "zero dividend sign", out_sign, 0);
    chk("R7", "zero dividend no div_err", out_div_err, 0);

    // R7: divide by zero
    apply(1'b1, 1'b0, 1'b0, 6'd4, 10'd10, 1'b1, 1'b1, 6'd2, 10'd30);
    chk("R7", "div_err", out_div_err, 1);
    chk("R7", "div_err out_zero", out_zero, 1);

    // R7: flag clears on next normal op
    apply(1'b1, 1'b0, 1'b0, 6'd4, 10'd10, 1'b0, 1'b0, 6'd2, 10'd5);
    chk("R7", "div_err cleared", out_div_err, 0);
    chk("R3", "after error exp", $signed(out_exp), 2);
    chk("R3", "after error frac", out_frac, 5);

    // R10: reset mid-run clears outputs
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10", "re-reset out_exp", out_exp, 0);
    chk("R10", "re-reset out_frac", out_frac, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule